// File: doc/BRIEF.md
# Composite Selectable Clock-Enable Divider

This block turns a set of single-cycle source strobes, all in one system clock domain, into one divided output strobe stream. A parent stage picks either the primary strobe or one of up to eight secondary strobes. A rate stage then divides the chosen stream by an effective ratio. The ratio is 3 when the fixed divide-by-3 path is switched in. Otherwise it is a value looked up from a 3-bit code when the programmable divider is switched in, and 1 when it is not. An output gate can mask the result.

Control fields sit in registers inside the block. Two write strobes load them: one takes a logical parent index, the other takes the rate and gate fields. The block reports the effective ratio and the current parent index so that a model can track them. Build-time parameters can remove the parent selector, which leaves the primary source fixed, or remove the gate, which leaves the output always on.

Top module: `clk_div_cell`

## Requirements
- R1: After reset `clk_en_o` is 0, `ratio_o` is 1, `parent_o` is 0, the divider is bypassed, divide-by-3 is off and the gate is closed.
- R2: A parent write with index k in 1..NUM_SEC selects `sec_stb_i[k-1]` and `parent_o` reads k from the next cycle. Index 0 selects `pri_stb_i` and `parent_o` reads 0.
- R3: A parent write with an index above NUM_SEC is ignored, and `parent_o` and the selected source are unchanged.
- R4: With divide switch 1 and divide-by-3 off, divide code 0..7 gives `ratio_o` 1, 2, 4, 6, 8, 12, 1, 1.
- R5: With divide switch 0 and divide-by-3 off, `ratio_o` is 1 whatever the divide code holds.
- R6: With divide-by-3 on, `ratio_o` is 3 whatever the divide switch and divide code hold.
- R7: With the gate open, `clk_en_o` is high for one cycle in the cycle after every N-th strobe of the selected source, where N is `ratio_o`. Strobes on sources that are not selected have no effect.
- R8: With the gate closed, `clk_en_o` stays 0 while the strobe count keeps running. Opening or closing the gate does not change the phase of the count.
- R9: A write that changes the effective ratio or the parent index clears the count, and a selected strobe in that same cycle is dropped. A write that changes neither leaves the count alone.
- R10: Without the selector (HAS_MUX=0), parent writes are ignored and `parent_o` stays 0. Without the gate (HAS_GATE=0), output strobes appear even when the gate field is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pri_stb_i | input | 1 | Primary source strobe |
| sec_stb_i | input | NUM_SEC | Secondary source strobes |
| par_we_i | input | 1 | Parent index write strobe |
| par_idx_i | input | IDX_W | Parent index: 0 primary, k secondary k-1 |
| cfg_we_i | input | 1 | Rate and gate field write strobe |
| cfg_div_sw_i | input | 1 | Divide switch: 1 applies lookup ratio |
| cfg_div_sel_i | input | 3 | Divide code for ratio lookup |
| cfg_d3_sw_i | input | 1 | Divide-by-3 switch, dominant |
| cfg_gate_en_i | input | 1 | Output gate enable |
| clk_en_o | output | 1 | Divided output strobe |
| ratio_o | output | 4 | Effective ratio |
| parent_o | output | IDX_W | Current parent index |

## Verification
A configuration write and a strobe from the selected source can fall on the same clock edge. That edge then both clears the count and would otherwise advance it or complete it. The bench provokes this by bringing the count one strobe short of a pulse, then writing a new ratio or a new parent with a strobe in the same cycle. It expects no output in that cycle, and a pulse only after N further strobes. The same collision with a write that changes neither ratio nor parent must still give the pulse at once.

// File: rtl/clk_div_cell_pkg.sv
package clk_div_cell_pkg;
  localparam int unsigned RATIO_W = 4;
  localparam int unsigned CODE_W  = 3;

  function automatic logic [RATIO_W-1:0] lut_ratio(input logic [CODE_W-1:0] code);
    case (code)
      3'd1:    lut_ratio = 4'd2;
      3'd2:    lut_ratio = 4'd4;
      3'd3:    lut_ratio = 4'd6;
      3'd4:    lut_ratio = 4'd8;
      3'd5:    lut_ratio = 4'd12;
      default: lut_ratio = 4'd1;
    endcase
  endfunction

  // d3 dominates, then divide switch, then table
  function automatic logic [RATIO_W-1:0] eff_ratio(input logic d3, input logic dsw,
                                                   input logic [CODE_W-1:0] code);
    if (d3)       eff_ratio = 4'd3;
    else if (dsw) eff_ratio = lut_ratio(code);
    else          eff_ratio = 4'd1;
  endfunction
endpackage

// File: rtl/clk_div_src_mux.sv
module clk_div_src_mux #(
  parameter int unsigned NUM_SEC = 8,
  parameter int unsigned SEL_W   = 3
) (
  input  logic               pri_stb_i,
  input  logic [NUM_SEC-1:0] sec_stb_i,
  input  logic               byp_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic               stb_o
);
  localparam int unsigned PAD_N = 2**SEL_W;

  logic [PAD_N-1:0] sec_pad;

  generate
    if (NUM_SEC < PAD_N) begin : g_pad
      assign sec_pad = {{(PAD_N-NUM_SEC){1'b0}}, sec_stb_i};
    end else begin : g_nopad
      assign sec_pad = sec_stb_i;
    end
  endgenerate

  always_comb begin
    stb_o = pri_stb_i;
    if (byp_i) stb_o = sec_pad[sel_i];
  end
endmodule

// File: rtl/clk_div_ctrl.sv
module clk_div_ctrl
  import clk_div_cell_pkg::*;
#(
  parameter int unsigned NUM_SEC  = 8,
  parameter bit          HAS_MUX  = 1'b1,
  parameter bit          HAS_GATE = 1'b1,
  parameter int unsigned SEL_W    = 3,
  parameter int unsigned IDX_W    = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               par_we_i,
  input  logic [IDX_W-1:0]   par_idx_i,
  input  logic               cfg_we_i,
  input  logic               cfg_div_sw_i,
  input  logic [CODE_W-1:0]  cfg_div_sel_i,
  input  logic               cfg_d3_sw_i,
  input  logic               cfg_gate_en_i,
  output logic               byp_o,
  output logic [SEL_W-1:0]   sel_o,
  output logic [RATIO_W-1:0] ratio_o,
  output logic               gate_o,
  output logic [IDX_W-1:0]   parent_o,
  output logic               chg_o
);
  localparam logic [IDX_W-1:0] MAX_IDX = IDX_W'(NUM_SEC);

  logic              dsw_q, dsw_d, d3_q, d3_d;
  logic [CODE_W-1:0] dsel_q, dsel_d;
  logic              byp_q, byp_d;
  logic [SEL_W-1:0]  sel_q, sel_d;
  logic [IDX_W-1:0]  parent_d;
  logic [RATIO_W-1:0] ratio_d;

  always_comb begin
    dsw_d  = dsw_q;
    dsel_d = dsel_q;
    d3_d   = d3_q;
    if (cfg_we_i) begin
      dsw_d  = cfg_div_sw_i;
      dsel_d = cfg_div_sel_i;
      d3_d   = cfg_d3_sw_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dsw_q  <= 1'b0;
      dsel_q <= '0;
      d3_q   <= 1'b0;
    end else begin
      dsw_q  <= dsw_d;
      dsel_q <= dsel_d;
      d3_q   <= d3_d;
    end
  end

  generate
    if (HAS_MUX) begin : g_mux
      always_comb begin
        byp_d = byp_q;
        sel_d = sel_q;
        if (par_we_i) begin
          if (par_idx_i == '0) begin
            byp_d = 1'b0;               // select field kept
          end else if (par_idx_i <= MAX_IDX) begin
            byp_d = 1'b1;
            sel_d = SEL_W'(par_idx_i - IDX_W'(1));
          end
        end
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          byp_q <= 1'b0;
          sel_q <= '0;
        end else begin
          byp_q <= byp_d;
          sel_q <= sel_d;
        end
      end
    end else begin : g_nomux
      logic unused_par;
      assign unused_par = ^{par_we_i, par_idx_i};
      assign byp_d = 1'b0;
      assign sel_d = '0;
      assign byp_q = 1'b0;
      assign sel_q = '0;
    end

    if (HAS_GATE) begin : g_gate
      logic gate_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       gate_q <= 1'b0;
        else if (cfg_we_i) gate_q <= cfg_gate_en_i;
      end
      assign gate_o = gate_q;
    end else begin : g_nogate
      logic unused_gate;
      assign unused_gate = cfg_gate_en_i;
      assign gate_o = 1'b1;
    end
  endgenerate

  assign parent_d = byp_d ? IDX_W'(sel_d) + IDX_W'(1) : '0;
  assign parent_o = byp_q ? IDX_W'(sel_q) + IDX_W'(1) : '0;
  assign ratio_d  = eff_ratio(d3_d, dsw_d, dsel_d);
  assign ratio_o  = eff_ratio(d3_q, dsw_q, dsel_q);
  assign chg_o    = (ratio_d != ratio_o) || (parent_d != parent_o);
  assign byp_o    = byp_q;
  assign sel_o    = sel_q;
endmodule

// File: rtl/clk_div_stb_div.sv
module clk_div_stb_div
  import clk_div_cell_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               stb_i,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic               clr_i,
  input  logic               gate_i,
  output logic               stb_o
);
  logic [RATIO_W-1:0] cnt_q;
  logic               last;

  assign last = (cnt_q == ratio_i - RATIO_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      stb_o <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      stb_o <= 1'b0;
    end else begin
      stb_o <= 1'b0;
      if (stb_i) begin
        if (last) begin
          cnt_q <= '0;
          stb_o <= gate_i;
        end else begin
          cnt_q <= cnt_q + RATIO_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/clk_div_cell.sv
module clk_div_cell
  import clk_div_cell_pkg::*;
#(
  parameter int unsigned NUM_SEC  = 8,
  parameter bit          HAS_MUX  = 1'b1,
  parameter bit          HAS_GATE = 1'b1,
  localparam int unsigned SEL_W   = (NUM_SEC > 1) ? $clog2(NUM_SEC) : 1,
  localparam int unsigned IDX_W   = $clog2(NUM_SEC + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pri_stb_i,
  input  logic [NUM_SEC-1:0] sec_stb_i,
  input  logic               par_we_i,
  input  logic [IDX_W-1:0]   par_idx_i,
  input  logic               cfg_we_i,
  input  logic               cfg_div_sw_i,
  input  logic [2:0]         cfg_div_sel_i,
  input  logic               cfg_d3_sw_i,
  input  logic               cfg_gate_en_i,
  output logic               clk_en_o,
  output logic [3:0]         ratio_o,
  output logic [IDX_W-1:0]   parent_o
);
  logic             byp_w, gate_w, chg_w, src_stb_w;
  logic [SEL_W-1:0] sel_w;

  clk_div_ctrl #(
    .NUM_SEC (NUM_SEC),
    .HAS_MUX (HAS_MUX),
    .HAS_GATE(HAS_GATE),
    .SEL_W   (SEL_W),
    .IDX_W   (IDX_W)
  ) i_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .par_we_i     (par_we_i),
    .par_idx_i    (par_idx_i),
    .cfg_we_i     (cfg_we_i),
    .cfg_div_sw_i (cfg_div_sw_i),
    .cfg_div_sel_i(cfg_div_sel_i),
    .cfg_d3_sw_i  (cfg_d3_sw_i),
    .cfg_gate_en_i(cfg_gate_en_i),
    .byp_o        (byp_w),
    .sel_o        (sel_w),
    .ratio_o      (ratio_o),
    .gate_o       (gate_w),
    .parent_o     (parent_o),
    .chg_o        (chg_w)
  );

  clk_div_src_mux #(
    .NUM_SEC(NUM_SEC),
    .SEL_W  (SEL_W)
  ) i_src (
    .pri_stb_i(pri_stb_i),
    .sec_stb_i(sec_stb_i),
    .byp_i    (byp_w),
    .sel_i    (sel_w),
    .stb_o    (src_stb_w)
  );

  clk_div_stb_div i_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stb_i  (src_stb_w),
    .ratio_i(ratio_o),
    .clr_i  (chg_w),
    .gate_i (gate_w),
    .stb_o  (clk_en_o)
  );
endmodule

// File: rtl/clk_div_cell_chk.sv
module clk_div_cell_chk #(
  parameter int unsigned NUM_SEC = 8,
  parameter bit          HAS_MUX = 1'b1,
  parameter int unsigned IDX_W   = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             par_we_i,
  input logic [IDX_W-1:0] par_idx_i,
  input logic             cfg_we_i,
  input logic             cfg_d3_sw_i,
  input logic             clk_en_o,
  input logic [3:0]       ratio_o,
  input logic [IDX_W-1:0] parent_o,
  input logic             gate_w,
  input logic             chg_w
);
  localparam logic [IDX_W-1:0] MAX_IDX = IDX_W'(NUM_SEC);

  p_parent_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (HAS_MUX && par_we_i && par_idx_i <= MAX_IDX) |=> parent_o == $past(par_idx_i));

  p_bad_idx_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_we_i && par_idx_i > MAX_IDX) |=> $stable(parent_o));

  p_ratio_legal_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ratio_o inside {4'd1, 4'd2, 4'd3, 4'd4, 4'd6, 4'd8, 4'd12});

  p_d3_dominant_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_d3_sw_i) |=> ratio_o == 4'd3);

  p_single_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_o && ratio_o > 4'd1) |=> !clk_en_o);

  p_gate_mask_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_w |=> !clk_en_o);

  p_change_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_w |=> !clk_en_o);
endmodule

bind clk_div_cell clk_div_cell_chk #(
  .NUM_SEC(NUM_SEC),
  .HAS_MUX(HAS_MUX),
  .IDX_W  (IDX_W)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .par_we_i   (par_we_i),
  .par_idx_i  (par_idx_i),
  .cfg_we_i   (cfg_we_i),
  .cfg_d3_sw_i(cfg_d3_sw_i),
  .clk_en_o   (clk_en_o),
  .ratio_o    (ratio_o),
  .parent_o   (parent_o),
  .gate_w     (gate_w),
  .chg_w      (chg_w)
);

// File: tb/test_clk_div_cell.sv
module test_clk_div_cell;
  localparam int CLK_PERIOD = 10;
  localparam int NSEC = 8;
  localparam int NVEC = 12;
  // {div_sw, div_sel[2:0], d3, exp_ratio[3:0]}
  localparam logic [8:0] VEC [NVEC] = '{
    {1'b1, 3'd0, 1'b0, 4'd1},  {1'b1, 3'd1, 1'b0, 4'd2},
    {1'b1, 3'd2, 1'b0, 4'd4},  {1'b1, 3'd3, 1'b0, 4'd6},
    {1'b1, 3'd4, 1'b0, 4'd8},  {1'b1, 3'd5, 1'b0, 4'd12},
    {1'b1, 3'd6, 1'b0, 4'd1},  {1'b1, 3'd7, 1'b0, 4'd1},
    {1'b0, 3'd5, 1'b0, 4'd1},  {1'b0, 3'd3, 1'b0, 4'd1},
    {1'b1, 3'd5, 1'b1, 4'd3},  {1'b0, 3'd2, 1'b1, 4'd3}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pri_stb = 1'b0;
  logic [NSEC-1:0] sec_stb = '0;
  logic par_we = 1'b0;
  logic [3:0] par_idx = '0;
  logic cfg_we = 1'b0, dsw = 1'b0, d3 = 1'b0, gate = 1'b0;
  logic [2:0] dsel = '0;
  logic clk_en, fx_en;
  logic [3:0] ratio, fx_ratio, parent, fx_parent;

  int checks = 0, errors = 0, pulses = 0;
  logic last_out = 1'b0, last_fx = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_div_cell i_clk_div_cell (
    .clk_i(clk), .rst_ni(rst_n), .pri_stb_i(pri_stb), .sec_stb_i(sec_stb),
    .par_we_i(par_we), .par_idx_i(par_idx), .cfg_we_i(cfg_we),
    .cfg_div_sw_i(dsw), .cfg_div_sel_i(dsel), .cfg_d3_sw_i(d3),
    .cfg_gate_en_i(gate), .clk_en_o(clk_en), .ratio_o(ratio), .parent_o(parent));

  clk_div_cell #(.HAS_MUX(1'b0), .HAS_GATE(1'b0)) i_clk_div_cell_fixed (
    .clk_i(clk), .rst_ni(rst_n), .pri_stb_i(pri_stb), .sec_stb_i(sec_stb),
    .par_we_i(par_we), .par_idx_i(par_idx), .cfg_we_i(cfg_we),
    .cfg_div_sw_i(dsw), .cfg_div_sel_i(dsel), .cfg_d3_sw_i(d3),
    .cfg_gate_en_i(gate), .clk_en_o(fx_en), .ratio_o(fx_ratio), .parent_o(fx_parent));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock edge; inputs set at a falling edge, output sampled at the next
  task automatic step(input logic p, input logic [NSEC-1:0] s);
    pri_stb = p;
    sec_stb = s;
    @(negedge clk);
    last_out = clk_en;
    last_fx  = fx_en;
    if (clk_en) pulses++;
    pri_stb = 1'b0;
    sec_stb = '0;
  endtask

  task automatic set_cfg(input logic sw, input logic [2:0] sel, input logic t,
                         input logic g, input logic p);
    cfg_we = 1'b1; dsw = sw; dsel = sel; d3 = t; gate = g;
    step(p, '0);
    cfg_we = 1'b0;
  endtask

  task automatic set_par(input logic [3:0] k, input logic p);
    par_we = 1'b1; par_idx = k;
    step(p, '0);
    par_we = 1'b0;
  endtask

  initial begin
    repeat (CLK_PERIOD * 200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 clk_en reset", clk_en, 0);
    chk("R1 ratio reset", ratio, 1);
    chk("R1 parent reset", parent, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // gate closed after reset; gateless instance still fires
    step(1'b1, '0);
    chk("R8 gate closed after reset", last_out, 0);
    chk("R10 no gate output on", last_fx, 1);

    set_par(4'd2, 1'b0);
    chk("R2 parent index 2", parent, 2);
    chk("R10 no selector parent", fx_parent, 0);
    step(1'b1, '0);
    chk("R10 no selector keeps primary", last_fx, 1);

    set_cfg(1'b0, 3'd0, 1'b0, 1'b1, 1'b0);
    step(1'b0, 8'b0000_0001);
    chk("R7 unselected secondary ignored", last_out, 0);
    step(1'b1, '0);
    chk("R7 unselected primary ignored", last_out, 0);
    step(1'b0, 8'b0000_0010);
    chk("R2 secondary 1 drives output", last_out, 1);
    set_par(4'd9, 1'b0);
    chk("R3 index 9 ignored", parent, 2);
    step(1'b0, 8'b0000_0010);
    chk("R3 source kept after bad index", last_out, 1);
    set_par(4'd0, 1'b0);
    chk("R2 parent index 0", parent, 0);
    step(1'b1, '0);
    chk("R2 primary drives output", last_out, 1);

    // ratio table walk: 2N strobes give exactly two pulses
    for (int i = 0; i < NVEC; i++) begin
      logic [3:0] n;
      logic hit;
      n = VEC[i][3:0];
      set_cfg(VEC[i][8], VEC[i][7:5], VEC[i][4], 1'b1, 1'b0);
      chk("R4 R5 R6 ratio", ratio, n);
      pulses = 0;
      hit = 1'b0;
      for (int k = 1; k <= 2 * n; k++) begin
        step(1'b1, '0);
        hit = last_out;
        if ((i % 2 == 1) && k < 2 * n) step(1'b0, '0);
      end
      chk("R7 pulses per 2N strobes", pulses, 2);
      chk("R7 pulse after Nth strobe", hit, 1);
    end

    // gate toggles keep phase
    set_cfg(1'b1, 3'd2, 1'b0, 1'b1, 1'b0);
    chk("R4 ratio 4", ratio, 4);
    step(1'b1, '0); step(1'b1, '0);
    set_cfg(1'b1, 3'd2, 1'b0, 1'b0, 1'b0);
    pulses = 0;
    step(1'b1, '0); step(1'b1, '0);
    chk("R8 gate closed masks pulse", pulses, 0);
    set_cfg(1'b1, 3'd2, 1'b0, 1'b1, 1'b0);
    for (int k = 0; k < 4; k++) step(1'b1, '0);
    chk("R8 phase kept across gate", pulses, 1);
    chk("R8 pulse on fourth strobe", last_out, 1);

    // ratio change colliding with a strobe
    for (int k = 0; k < 3; k++) step(1'b1, '0);
    set_cfg(1'b1, 3'd1, 1'b0, 1'b1, 1'b1);
    chk("R9 strobe dropped on ratio change", last_out, 0);
    pulses = 0;
    step(1'b1, '0);
    chk("R9 count restarted", last_out, 0);
    step(1'b1, '0);
    chk("R9 pulse after N new strobes", pulses, 1);

    // same-value write does not disturb
    step(1'b1, '0);
    set_cfg(1'b1, 3'd1, 1'b0, 1'b1, 1'b1);
    chk("R9 unchanged write keeps count", last_out, 1);

    // parent change colliding with a strobe
    step(1'b1, '0);
    set_par(4'd1, 1'b1);
    chk("R9 strobe dropped on parent change", last_out, 0);
    step(1'b0, 8'b0000_0001);
    chk("R9 parent change restarts count", last_out, 0);
    step(1'b0, 8'b0000_0001);
    chk("R9 pulse on new parent", last_out, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule